// File: doc/BRIEF.md
# Copy Engine Register Block

This block is the software-visible register file of a multi-channel memory copy engine. A simple request/response register bus reaches it with 1-, 2-, 4- and 8-byte accesses. The first 128 bytes of the space hold engine-wide registers. After them, each channel has its own 128-byte window. Every request gets a registered response one cycle later. Illegal accesses return an error flag and zero data, and they leave all state as it was.

Several registers change state when they are accessed. Attention status clears when read. Reading interrupt control drops the master enable. Reading a channel control register marks that channel as in use. The error register clears the bits written as 1. The two 64-bit address registers can be updated one 32-bit half at a time. A write to the command register sends a one-cycle strobe and the command byte to that channel's engine. The chain and completion addresses, the control word and the master enable are driven out to the channel engines. Busy, status and error-set inputs come back from those engines.

Top module: `ce_regblock`

## Requirements
- R1: Every request cycle (req_i=1) is answered in the following cycle with ack_o=1. On a legal read, rdata_o carries the register value. On a write or an error, rdata_o is zero. Size codes are 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes.
- R2: Global offset 0x00 (1 byte) reads the NCH parameter. Offset 0x01 (1 byte) reads the bit index of the most significant set bit of XFER_BYTES.
- R3: Global offset 0x08 (4 bytes) is attention status. Bits pulsed on attn_set_i accumulate there, and a read returns the value and then clears it. Writes to offsets 0x00, 0x01 and 0x08 change nothing.
- R4: Global offset 0x04 (1 byte) is interrupt control, with the master enable in bit 0. A write loads bit 0. A read returns the value and then clears the enable. mie_o shows the enable.
- R5: A read of channel offset 0x00 (control, 2 bytes) returns the control word and then sets its bit 0 (in use).
- R6: A control write loads bits 15:2 and bit 0 from the write data. For bit 1 (interrupt disable), a written 1 clears the bit and a written 0 keeps the old value.
- R7: A read of channel offset 0x08 (status, 8 bytes) returns that channel's engine status with bit 0 forced to 1 while its busy input is low.
- R8: Chain address is at channel offsets 0x10 (low) and 0x14 (high), and completion address at 0x18 (low) and 0x1C (high). An 8-byte write to the low offset replaces all 64 bits. A 4-byte write to the low offset replaces only bits 31:0. A 4-byte write to the high offset replaces only bits 63:32.
- R9: Channel offset 0x20 (error, 4 bytes) collects the bits pulsed by the engine. A write clears each bit written as 1 and keeps the rest.
- R10: A 1-byte write to channel offset 0x02 (command) raises that channel's cmd_stb_o bit for exactly one cycle, with the byte on its cmd_o slice. The register reads zero afterwards.
- R11: An access to a channel index at or above NCH, to an undefined offset, or with a size the register does not accept gets err_o=1 and zero data. It changes no register and raises no strobe.
- R12: Channel n owns addresses 0x80*(n+1) to 0x80*(n+1)+0x7F. An access there touches only channel n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset in the register space |
| size_i | input | 2 | Access size code |
| wdata_i | input | 64 | Write data, right-aligned |
| ack_o | output | 1 | Response valid |
| err_o | output | 1 | Response is an error |
| rdata_o | output | 64 | Read data, right-aligned |
| ch_busy_i | input | NCH | Per-channel busy from the engines |
| ch_status_i | input | NCH*64 | Per-channel status word from the engines |
| ch_err_set_i | input | NCH*32 | Per-channel error bits to set |
| attn_set_i | input | 32 | Attention bits to set |
| mie_o | output | 1 | Master interrupt enable |
| ctrl_o | output | NCH*16 | Per-channel control word |
| chain_o | output | NCH*64 | Per-channel descriptor chain address |
| cpl_o | output | NCH*64 | Per-channel completion address |
| cmd_stb_o | output | NCH | Per-channel command strobe |
| cmd_o | output | NCH*8 | Per-channel command byte |

## Verification
The bench reads each side-effect register twice in a row. A design that forgot the clear or the set, or that applied it before the read data was captured, returns the same or the wrong value on one of the two reads. Half-word address merges are checked against a known 64-bit pattern, so a merge that overwrites the other half shows up. The interrupt-disable bit is written both set and clear, which exposes a design that simply stores the written value. Rejected accesses (a channel beyond the count, an undefined offset, a wrong size) are each followed by a read or a port check. That catches a design that raises the error flag but still updates the register or strobes the channel.

// File: rtl/ce_reg_pkg.sv
package ce_reg_pkg;
  localparam int WIN_LSB = 7;  // 128-byte windows

  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_W = 2'd2;
  localparam logic [1:0] SZ_D = 2'd3;

  localparam logic [6:0] G_OFF_COUNT = 7'h00;
  localparam logic [6:0] G_OFF_CAP   = 7'h01;
  localparam logic [6:0] G_OFF_IRQ   = 7'h04;
  localparam logic [6:0] G_OFF_ATTN  = 7'h08;

  localparam logic [6:0] C_OFF_CTRL  = 7'h00;
  localparam logic [6:0] C_OFF_CMD   = 7'h02;
  localparam logic [6:0] C_OFF_STAT  = 7'h08;
  localparam logic [6:0] C_OFF_CHLO  = 7'h10;
  localparam logic [6:0] C_OFF_CHHI  = 7'h14;
  localparam logic [6:0] C_OFF_CPLO  = 7'h18;
  localparam logic [6:0] C_OFF_CPHI  = 7'h1C;
  localparam logic [6:0] C_OFF_ERR   = 7'h20;

  localparam int CTRL_INUSE  = 0;
  localparam int CTRL_IRQDIS = 1;

  typedef enum logic [2:0] {G_NONE, G_COUNT, G_CAP, G_IRQ, G_ATTN} glob_reg_e;
  typedef enum logic [3:0] {
    C_NONE, C_CTRL, C_CMD, C_STAT, C_CHAIN_LO, C_CHAIN_HI, C_CPL_LO, C_CPL_HI, C_ERR
  } chan_reg_e;
endpackage

// File: rtl/ce_addr_dec.sv
module ce_addr_dec
  import ce_reg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NCH    = 4,
  localparam int WIN_W = ADDR_W - WIN_LSB
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic              glob_o,
  output glob_reg_e         gsel_o,
  output chan_reg_e         csel_o,
  output logic [WIN_W-1:0]  idx_o,
  output logic              ok_o
);
  logic [6:0]       off;
  logic [WIN_W-1:0] win;

  assign off    = addr_i[WIN_LSB-1:0];
  assign win    = addr_i[ADDR_W-1:WIN_LSB];
  assign glob_o = (win == '0);
  assign idx_o  = win - WIN_W'(1);

  always_comb begin
    gsel_o = G_NONE;
    unique case (off)
      G_OFF_COUNT: if (size_i == SZ_B) gsel_o = G_COUNT;
      G_OFF_CAP:   if (size_i == SZ_B) gsel_o = G_CAP;
      G_OFF_IRQ:   if (size_i == SZ_B) gsel_o = G_IRQ;
      G_OFF_ATTN:  if (size_i == SZ_W) gsel_o = G_ATTN;
      default:     gsel_o = G_NONE;
    endcase
  end

  always_comb begin
    csel_o = C_NONE;
    unique case (off)
      C_OFF_CTRL: if (size_i == SZ_H) csel_o = C_CTRL;
      C_OFF_CMD:  if (size_i == SZ_B) csel_o = C_CMD;
      C_OFF_STAT: if (size_i == SZ_D) csel_o = C_STAT;
      C_OFF_CHLO: if (size_i == SZ_W || size_i == SZ_D) csel_o = C_CHAIN_LO;
      C_OFF_CHHI: if (size_i == SZ_W) csel_o = C_CHAIN_HI;
      C_OFF_CPLO: if (size_i == SZ_W || size_i == SZ_D) csel_o = C_CPL_LO;
      C_OFF_CPHI: if (size_i == SZ_W) csel_o = C_CPL_HI;
      C_OFF_ERR:  if (size_i == SZ_W) csel_o = C_ERR;
      default:    csel_o = C_NONE;
    endcase
  end

  assign ok_o = glob_o ? (gsel_o != G_NONE)
                       : ((csel_o != C_NONE) && (idx_o < WIN_W'(NCH)));
endmodule

// File: rtl/ce_glob_regs.sv
module ce_glob_regs
  import ce_reg_pkg::*;
#(
  parameter int          NCH        = 4,
  parameter int unsigned XFER_BYTES = 32'h0010_0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rd_i,
  input  logic        wr_i,
  input  glob_reg_e   sel_i,
  input  logic        wbit_i,
  input  logic [31:0] attn_set_i,
  output logic [63:0] rdata_o,
  output logic        mie_o
);
  function automatic logic [7:0] msb_idx(input int unsigned v);
    logic [7:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) if (v[i]) r = 8'(i);
    return r;
  endfunction

  localparam logic [7:0] CNT_VAL = 8'(NCH);
  localparam logic [7:0] CAP_VAL = msb_idx(XFER_BYTES);

  logic [31:0] attn_q;
  logic        mie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      attn_q <= '0;
      mie_q  <= 1'b0;
    end else begin
      attn_q <= ((rd_i && sel_i == G_ATTN) ? 32'h0 : attn_q) | attn_set_i;
      if (wr_i && sel_i == G_IRQ)      mie_q <= wbit_i;
      else if (rd_i && sel_i == G_IRQ) mie_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (sel_i)
      G_COUNT: rdata_o = {56'h0, CNT_VAL};
      G_CAP:   rdata_o = {56'h0, CAP_VAL};
      G_IRQ:   rdata_o = {63'h0, mie_q};
      G_ATTN:  rdata_o = {32'h0, attn_q};
      default: rdata_o = '0;
    endcase
  end

  assign mie_o = mie_q;
endmodule

// File: rtl/ce_chan_regs.sv
module ce_chan_regs
  import ce_reg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        we_i,
  input  chan_reg_e   sel_i,
  input  logic [1:0]  size_i,
  input  logic [63:0] wdata_i,
  input  logic        busy_i,
  input  logic [63:0] status_i,
  input  logic [31:0] err_set_i,
  output logic [63:0] rdata_o,
  output logic [15:0] ctrl_o,
  output logic [63:0] chain_o,
  output logic [63:0] cpl_o,
  output logic        cmd_stb_o,
  output logic [7:0]  cmd_o
);
  logic [15:0] ctrl_q;
  logic [63:0] chain_q, cpl_q;
  logic [31:0] err_q, err_clr;
  logic [7:0]  cmd_q;
  logic        stb_q, wr, rd;

  assign wr      = en_i && we_i;
  assign rd      = en_i && !we_i;
  assign err_clr = (wr && sel_i == C_ERR) ? wdata_i[31:0] : 32'h0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      chain_q <= '0;
      cpl_q   <= '0;
      err_q   <= '0;
      cmd_q   <= '0;
      stb_q   <= 1'b0;
    end else begin
      err_q <= (err_q & ~err_clr) | err_set_i;
      cmd_q <= '0;
      stb_q <= 1'b0;
      if (rd && sel_i == C_CTRL) ctrl_q[CTRL_INUSE] <= 1'b1;
      if (wr) begin
        unique case (sel_i)
          C_CTRL: ctrl_q <= {wdata_i[15:2],
                             wdata_i[CTRL_IRQDIS] ? 1'b0 : ctrl_q[CTRL_IRQDIS],
                             wdata_i[CTRL_INUSE]};
          C_CMD: begin
            cmd_q <= wdata_i[7:0];
            stb_q <= 1'b1;
          end
          C_CHAIN_LO: if (size_i == SZ_D) chain_q <= wdata_i;
                      else chain_q[31:0] <= wdata_i[31:0];
          C_CHAIN_HI: chain_q[63:32] <= wdata_i[31:0];
          C_CPL_LO:   if (size_i == SZ_D) cpl_q <= wdata_i;
                      else cpl_q[31:0] <= wdata_i[31:0];
          C_CPL_HI:   cpl_q[63:32] <= wdata_i[31:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (sel_i)
      C_CTRL:     rdata_o = {48'h0, ctrl_q};
      C_CMD:      rdata_o = {56'h0, cmd_q};
      C_STAT:     rdata_o = status_i | {63'h0, !busy_i};
      C_CHAIN_LO: rdata_o = (size_i == SZ_D) ? chain_q : {32'h0, chain_q[31:0]};
      C_CHAIN_HI: rdata_o = {32'h0, chain_q[63:32]};
      C_CPL_LO:   rdata_o = (size_i == SZ_D) ? cpl_q : {32'h0, cpl_q[31:0]};
      C_CPL_HI:   rdata_o = {32'h0, cpl_q[63:32]};
      C_ERR:      rdata_o = {32'h0, err_q};
      default:    rdata_o = '0;
    endcase
  end

  assign ctrl_o    = ctrl_q;
  assign chain_o   = chain_q;
  assign cpl_o     = cpl_q;
  assign cmd_stb_o = stb_q;
  assign cmd_o     = cmd_q;
endmodule

// File: rtl/ce_regblock.sv
module ce_regblock
  import ce_reg_pkg::*;
#(
  parameter int          NCH        = 4,
  parameter int          ADDR_W     = 16,
  parameter int unsigned XFER_BYTES = 32'h0010_0000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [1:0]          size_i,
  input  logic [63:0]         wdata_i,
  output logic                ack_o,
  output logic                err_o,
  output logic [63:0]         rdata_o,
  input  logic [NCH-1:0]      ch_busy_i,
  input  logic [NCH*64-1:0]   ch_status_i,
  input  logic [NCH*32-1:0]   ch_err_set_i,
  input  logic [31:0]         attn_set_i,
  output logic                mie_o,
  output logic [NCH*16-1:0]   ctrl_o,
  output logic [NCH*64-1:0]   chain_o,
  output logic [NCH*64-1:0]   cpl_o,
  output logic [NCH-1:0]      cmd_stb_o,
  output logic [NCH*8-1:0]    cmd_o
);
  localparam int WIN_W = ADDR_W - WIN_LSB;

  logic             is_glob, ok, acc;
  glob_reg_e        gsel;
  chan_reg_e        csel;
  logic [WIN_W-1:0] idx;
  logic [63:0]      g_rd, rd_mux;
  logic [63:0]      c_rd [NCH];
  logic [NCH-1:0]   c_en;

  ce_addr_dec #(.ADDR_W(ADDR_W), .NCH(NCH)) u_dec (
    .addr_i(addr_i), .size_i(size_i), .glob_o(is_glob), .gsel_o(gsel),
    .csel_o(csel), .idx_o(idx), .ok_o(ok)
  );

  assign acc = req_i && ok;

  ce_glob_regs #(.NCH(NCH), .XFER_BYTES(XFER_BYTES)) u_glob (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_i(acc && is_glob && !we_i), .wr_i(acc && is_glob && we_i),
    .sel_i(is_glob ? gsel : G_NONE), .wbit_i(wdata_i[0]),
    .attn_set_i(attn_set_i), .rdata_o(g_rd), .mie_o(mie_o)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign c_en[k] = acc && !is_glob && (idx == WIN_W'(k));
    ce_chan_regs u_ch (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(c_en[k]), .we_i(we_i),
      .sel_i(csel), .size_i(size_i), .wdata_i(wdata_i),
      .busy_i(ch_busy_i[k]), .status_i(ch_status_i[k*64 +: 64]),
      .err_set_i(ch_err_set_i[k*32 +: 32]), .rdata_o(c_rd[k]),
      .ctrl_o(ctrl_o[k*16 +: 16]), .chain_o(chain_o[k*64 +: 64]),
      .cpl_o(cpl_o[k*64 +: 64]), .cmd_stb_o(cmd_stb_o[k]),
      .cmd_o(cmd_o[k*8 +: 8])
    );
  end

  always_comb begin
    rd_mux = is_glob ? g_rd : 64'h0;
    for (int k = 0; k < NCH; k++) if (c_en[k]) rd_mux = c_rd[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      err_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o   <= req_i;
      err_o   <= req_i && !ok;
      rdata_o <= (acc && !we_i) ? rd_mux : 64'h0;
    end
  end
endmodule

// File: rtl/ce_regblock_chk.sv
module ce_regblock_chk #(
  parameter int NCH    = 4,
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        size_i,
  input logic              ack_o,
  input logic              err_o,
  input logic [63:0]       rdata_o,
  input logic              mie_o,
  input logic [NCH-1:0]    cmd_stb_o,
  input logic [NCH*64-1:0] chain_o
);
  assert_ack_follows_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ack_o);

  assert_err_zero_data_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == 64'h0));

  assert_irq_read_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_W'(4) && size_i == 2'd0) |=> !mie_o);

  assert_chain_hi_keeps_lo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(16'h94) && size_i == 2'd2)
      |=> (chain_o[31:0] == $past(chain_o[31:0])));

  assert_single_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_stb_o));

  assert_strobe_after_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_stb_o != '0) |-> $past(req_i && we_i));
endmodule

bind ce_regblock ce_regblock_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .size_i(size_i), .ack_o(ack_o), .err_o(err_o), .rdata_o(rdata_o),
  .mie_o(mie_o), .cmd_stb_o(cmd_stb_o), .chain_o(chain_o)
);

// File: tb/sim_ce_regblock.sv
module sim_ce_regblock;
  localparam int NCH = 4;
  localparam int AW  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0, we = 1'b0;
  logic [AW-1:0]     addr = '0;
  logic [1:0]        size = '0;
  logic [63:0]       wdata = '0;
  logic              ack, err;
  logic [63:0]       rdata;
  logic [NCH-1:0]    busy = '0;
  logic [NCH*64-1:0] status = '0;
  logic [NCH*32-1:0] err_set = '0;
  logic [31:0]       attn_set = '0;
  logic              mie;
  logic [NCH*16-1:0] ctrl;
  logic [NCH*64-1:0] chain, cpl;
  logic [NCH-1:0]    stb;
  logic [NCH*8-1:0]  cmd;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [63:0] exp_d_q [$];
  bit          exp_e_q [$];
  string       tag_q   [$];

  always #10 clk = ~clk;  // 50 MHz

  ce_regblock #(.NCH(NCH), .ADDR_W(AW), .XFER_BYTES(32'h0010_0000)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .ack_o(ack), .err_o(err), .rdata_o(rdata),
    .ch_busy_i(busy), .ch_status_i(status), .ch_err_set_i(err_set),
    .attn_set_i(attn_set), .mie_o(mie), .ctrl_o(ctrl), .chain_o(chain),
    .cpl_o(cpl), .cmd_stb_o(stb), .cmd_o(cmd)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one request cycle, expected response queued for the monitor
  task automatic acc(input bit w, input logic [AW-1:0] a, input logic [1:0] sz,
                     input logic [63:0] wd, input logic [63:0] exp, input bit exp_err,
                     input string tag);
    req = 1'b1; we = w; addr = a; size = sz; wdata = wd;
    exp_d_q.push_back(exp); exp_e_q.push_back(exp_err); tag_q.push_back(tag);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [1:0] sz,
                    input logic [63:0] exp, input string tag);
    acc(1'b0, a, sz, 64'h0, exp, 1'b0, tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [1:0] sz,
                    input logic [63:0] wd, input string tag);
    acc(1'b1, a, sz, wd, 64'h0, 1'b0, tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && ack) begin
      if (exp_d_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1 unexpected ack actual=1 expected=0");
      end else begin
        string t;
        logic [63:0] ed;
        bit ee;
        t = tag_q.pop_front(); ed = exp_d_q.pop_front(); ee = exp_e_q.pop_front();
        chk({t, " data"}, rdata, ed);
        chk({t, " err"}, {63'h0, err}, {63'h0, ee});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    status[2*64 +: 64] = 64'hA0;
    repeat (3) @(negedge clk);
    // reset state
    chk("R1 reset ack", {63'h0, ack}, 64'h0);
    chk("R1 reset rdata", rdata, 64'h0);
    chk("R10 reset strobe", {60'h0, stb}, 64'h0);
    chk("R8 reset chain", chain[63:0], 64'h0);
    chk("R4 reset mie", {63'h0, mie}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 constants
    rd(16'h000, 2'd0, 64'd4,  "R2 count");
    rd(16'h001, 2'd0, 64'd20, "R2 cap");
    wr(16'h000, 2'd0, 64'h9,  "R3 write count");
    wr(16'h001, 2'd0, 64'h3,  "R3 write cap");
    rd(16'h000, 2'd0, 64'd4,  "R3 count unchanged");
    rd(16'h001, 2'd0, 64'd20, "R3 cap unchanged");

    // R3 attention
    attn_set = 32'h5; @(negedge clk); attn_set = 32'h0;
    rd(16'h008, 2'd2, 64'h5, "R3 attn value");
    rd(16'h008, 2'd2, 64'h0, "R3 attn cleared");
    attn_set = 32'h2; @(negedge clk); attn_set = 32'h0;
    wr(16'h008, 2'd2, 64'hFFFF_FFFF, "R3 attn write");
    rd(16'h008, 2'd2, 64'h2, "R3 attn write ignored");

    // R4 interrupt control
    wr(16'h004, 2'd0, 64'h1, "R4 mie write");
    chk("R4 mie out", {63'h0, mie}, 64'h1);
    acc(1'b0, 16'h004, 2'd2, 64'h0, 64'h0, 1'b1, "R11 irq wrong size");
    chk("R11 mie kept", {63'h0, mie}, 64'h1);
    rd(16'h004, 2'd0, 64'h1, "R4 mie read");
    rd(16'h004, 2'd0, 64'h0, "R4 mie cleared");
    chk("R4 mie out cleared", {63'h0, mie}, 64'h0);

    // R5 / R6 control
    rd(16'h100, 2'd1, 64'h0, "R5 ctrl first read");
    rd(16'h100, 2'd1, 64'h1, "R5 ctrl in use");
    chk("R5 ctrl out", {48'h0, ctrl[1*16 +: 16]}, 64'h1);
    wr(16'h100, 2'd1, 64'h0006, "R6 ctrl write");
    rd(16'h100, 2'd1, 64'h0004, "R6 irq disable cleared");
    wr(16'h100, 2'd1, 64'h8001, "R6 ctrl write bit0");
    rd(16'h100, 2'd1, 64'h8001, "R6 ctrl value");
    chk("R12 ctrl ch0 untouched", {48'h0, ctrl[0 +: 16]}, 64'h0);

    // R7 status
    rd(16'h188, 2'd3, 64'hA1, "R7 status idle");
    busy[2] = 1'b1;
    rd(16'h188, 2'd3, 64'hA0, "R7 status busy");
    busy[2] = 1'b0;

    // R8 address merges
    wr(16'h090, 2'd3, 64'h1122_3344_5566_7788, "R8 chain 64");
    chk("R8 chain out", chain[0 +: 64], 64'h1122_3344_5566_7788);
    wr(16'h094, 2'd2, 64'hAABB_CCDD, "R8 chain hi");
    rd(16'h090, 2'd3, 64'hAABB_CCDD_5566_7788, "R8 chain after hi");
    wr(16'h090, 2'd2, 64'h0102_0304, "R8 chain lo");
    rd(16'h090, 2'd3, 64'hAABB_CCDD_0102_0304, "R8 chain after lo");
    rd(16'h094, 2'd2, 64'hAABB_CCDD, "R8 chain hi read");
    wr(16'h218, 2'd3, 64'hDEAD_BEEF_CAFE_F00D, "R8 cpl 64");
    wr(16'h21C, 2'd2, 64'h1234_5678, "R8 cpl hi");
    rd(16'h218, 2'd2, 64'hCAFE_F00D, "R8 cpl lo read");
    chk("R12 cpl ch3", cpl[3*64 +: 64], 64'h1234_5678_CAFE_F00D);
    chk("R12 cpl ch0 untouched", cpl[0 +: 64], 64'h0);

    // R9 error
    err_set[0 +: 32] = 32'hF0; @(negedge clk); err_set = '0;
    rd(16'h0A0, 2'd2, 64'hF0, "R9 err set");
    wr(16'h0A0, 2'd2, 64'h30, "R9 err clear");
    rd(16'h0A0, 2'd2, 64'hC0, "R9 err after clear");

    // R10 command
    wr(16'h182, 2'd0, 64'h5A, "R10 cmd write");
    chk("R10 strobe", {60'h0, stb}, 64'h4);
    chk("R10 cmd byte", {56'h0, cmd[2*8 +: 8]}, 64'h5A);
    @(negedge clk);
    chk("R10 strobe one cycle", {60'h0, stb}, 64'h0);
    rd(16'h182, 2'd0, 64'h0, "R10 cmd reads zero");

    // R11 illegal accesses
    acc(1'b0, 16'h280, 2'd1, 64'h0, 64'h0, 1'b1, "R11 channel out of range");
    acc(1'b1, 16'h282, 2'd0, 64'h77, 64'h0, 1'b1, "R11 cmd out of range");
    chk("R11 no strobe", {60'h0, stb}, 64'h0);
    acc(1'b0, 16'h00C, 2'd2, 64'h0, 64'h0, 1'b1, "R11 undefined global");
    acc(1'b1, 16'h090, 2'd1, 64'hFFFF, 64'h0, 1'b1, "R11 chain wrong size");
    rd(16'h090, 2'd3, 64'hAABB_CCDD_0102_0304, "R11 chain unchanged");
    acc(1'b1, 16'h0A8, 2'd2, 64'h1, 64'h0, 1'b1, "R11 undefined channel offset");

    repeat (3) @(negedge clk);
    chk("R1 responses drained", 64'(exp_d_q.size()), 64'h0);
    finish_run();
  end
endmodule